// File: doc/BRIEF.md
# Process-Tagged Translation Buffer

This block is a four-entry, fully associative translation buffer for user-mode memory accesses. Each entry has two 32-bit words. The tag word holds a virtual page number, a process number and a write-permission flag. The physical word holds the page frame. Software fills the entries through a small write window, and the block does no replacement or table walking of its own.

A lookup presents a virtual address, a process number, a user-mode flag and a write flag, qualified by `req_valid`. The result is combinational in the same cycle. The block returns one of three things:
- the translated address, on a hit;
- the unchanged address, when translation is bypassed;
- a fault, on a miss or a denied write.

On a fault the faulting page is latched into a fault-address register at the next clock edge, and a pending interrupt flag is raised. The lookup port always accepts: there is no back-pressure, and every cycle with `req_valid` high is one lookup answered in that cycle.

Top module: `proc_tlb`

## Requirements
- R1: The write window is addressed by `cfg_addr`, a byte offset. Bits [4:3] select the entry (0..3), bit 2 selects the word (0 = tag, 1 = physical), and bits [1:0] are ignored. A write with `cfg_we` high takes effect at the clock edge, and later lookups use the value written, including a value that replaces an earlier one.
- R2: On a hit, `rsp_paddr` equals the physical word of the entry, bitwise ORed with `req_vaddr[11:0]`.
- R3: An entry matches when (tag with bit 0 cleared) equals (`req_vaddr` with bits [11:0] cleared) ORed with (`req_pid` shifted left by one).
- R4: Tag bit 0 is the write-permission flag. A lookup with `req_write` high hits only if this flag is 1. A read lookup ignores the flag.
- R5: When `req_user` is 0 or `req_pid` is 0, the lookup is bypassed. In that case `rsp_paddr` equals `req_vaddr`, and both `rsp_hit` and `rsp_fault` are 0.
- R6: A translated lookup with no qualifying entry raises `rsp_fault` in the same cycle. `rsp_paddr` then equals `req_vaddr`. At the next edge, `fault_addr` takes `req_vaddr` with bits [11:0] cleared and `irq_pending` becomes 1. Both hold their values otherwise.
- R7: Any write to the window clears `irq_pending` at the edge. If a fault occurs in the same cycle as such a write, the fault wins and `irq_pending` is 1.
- R8: When several entries qualify, the entry with the lowest index supplies the physical word.
- R9: After reset, all entry words, `fault_addr` and `irq_pending` are 0. A translated lookup with a nonzero process number then faults.
- R10: With `req_valid` at 0, `rsp_hit` and `rsp_fault` are 0, and `fault_addr` and `irq_pending` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the entry window |
| cfg_addr | input | 5 | Byte offset into the entry window |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request present (always accepted) |
| req_vaddr | input | 32 | Virtual address |
| req_pid | input | 8 | Process number |
| req_user | input | 1 | Access is made in user mode |
| req_write | input | 1 | Access is a store |
| rsp_paddr | output | 32 | Translated or passed-through address |
| rsp_hit | output | 1 | A translated lookup found a qualifying entry |
| rsp_fault | output | 1 | A translated lookup missed or was denied |
| fault_addr | output | 32 | Page of the most recent fault |
| irq_pending | output | 1 | Translation interrupt pending |

## Verification
The assertions check the following on every cycle:
- the bypass path passes the address through unchanged;
- hit and fault are exclusive;
- the page offset survives a hit;
- the fault register and interrupt flag follow each fault and hold their value otherwise;
- a window write clears the flag unless a fault arrives in the same cycle.

Only the bench scenarios can show the rest. These are the match on process number and page, the write-permission check, lowest-index priority between duplicate entries, and the OR of the physical word's low bits into the result. They also include the window decode that places a written word in the correct entry and field, and the reset contents.

// File: rtl/proc_tlb_pkg.sv
package proc_tlb_pkg;
  localparam int WORD_W = 32;
  localparam int PAGE_SHIFT = 12;

  typedef struct packed {
    logic [WORD_W-1:0] vtag;
    logic [WORD_W-1:0] pframe;
  } tlb_slot_t;
endpackage

// File: rtl/tlb_slot_bank.sv
module tlb_slot_bank
  import proc_tlb_pkg::*;
#(
  parameter int N_SLOTS = 4,
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic                     wr_frame,
  input  logic [WORD_W-1:0]        wr_data,
  output tlb_slot_t [N_SLOTS-1:0]  slots
);
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slots[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        if (wr_frame) slots[g].pframe <= wr_data;
        else          slots[g].vtag   <= wr_data;
      end
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import proc_tlb_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int PID_W = 8
) (
  input  tlb_slot_t [N_SLOTS-1:0] slots,
  input  logic [WORD_W-1:0]       vaddr,
  input  logic [PID_W-1:0]        pid,
  input  logic                    is_store,
  output logic                    found,
  output logic [WORD_W-1:0]       frame
);
  logic [WORD_W-1:0]  key;
  logic [N_SLOTS-1:0] qual;

  always_comb begin
    key = {vaddr[WORD_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}}
        | (WORD_W'(pid) << 1);
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
    assign qual[g] = ((slots[g].vtag & ~WORD_W'(1)) == key)
                   && (!is_store || slots[g].vtag[0]);
  end

  always_comb begin
    found = |qual;
    frame = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (qual[i]) frame = slots[i].pframe;
    end
  end
endmodule

// File: rtl/tlb_fault_reg.sv
module tlb_fault_reg
  import proc_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_ev,
  input  logic [WORD_W-1:0] fault_va,
  input  logic              irq_clr,
  output logic [WORD_W-1:0] fault_page,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_page <= '0;
      irq        <= 1'b0;
    end else begin
      if (fault_ev) begin
        fault_page <= {fault_va[WORD_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        irq        <= 1'b1;
      end else if (irq_clr) begin
        irq        <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/proc_tlb.sv
module proc_tlb
  import proc_tlb_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int PID_W = 8,
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CFG_AW = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [WORD_W-1:0] req_vaddr,
  input  logic [PID_W-1:0]  req_pid,
  input  logic              req_user,
  input  logic              req_write,
  output logic [WORD_W-1:0] rsp_paddr,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [WORD_W-1:0] fault_addr,
  output logic              irq_pending
);
  tlb_slot_t [N_SLOTS-1:0] slots;
  logic                    found;
  logic [WORD_W-1:0]       frame;
  logic                    xlate;

  tlb_slot_bank #(.N_SLOTS(N_SLOTS)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_addr[CFG_AW-1:3]),
    .wr_frame (cfg_addr[2]),
    .wr_data  (cfg_wdata),
    .slots    (slots)
  );

  tlb_match #(.N_SLOTS(N_SLOTS), .PID_W(PID_W)) match_i (
    .slots    (slots),
    .vaddr    (req_vaddr),
    .pid      (req_pid),
    .is_store (req_write),
    .found    (found),
    .frame    (frame)
  );

  assign xlate     = req_valid && req_user && (req_pid != '0);
  assign rsp_hit   = xlate && found;
  assign rsp_fault = xlate && !found;
  assign rsp_paddr = rsp_hit
                   ? (frame | WORD_W'(req_vaddr[PAGE_SHIFT-1:0]))
                   : req_vaddr;

  tlb_fault_reg fault_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_ev   (rsp_fault),
    .fault_va   (req_vaddr),
    .irq_clr    (cfg_we),
    .fault_page (fault_addr),
    .irq        (irq_pending)
  );
endmodule

// File: rtl/proc_tlb_chk.sv
module proc_tlb_chk #(
  parameter int CFG_AW = 5,
  parameter int PID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic              req_valid,
  input logic [31:0]       req_vaddr,
  input logic [PID_W-1:0]  req_pid,
  input logic              req_user,
  input logic [31:0]       rsp_paddr,
  input logic              rsp_hit,
  input logic              rsp_fault,
  input logic [31:0]       fault_addr,
  input logic              irq_pending
);
  p_bypass_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (!req_user || req_pid == '0))
      |-> (rsp_paddr == req_vaddr && !rsp_hit && !rsp_fault));

  p_hit_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> ((rsp_paddr[11:0] & req_vaddr[11:0]) == req_vaddr[11:0]));

  p_fault_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |=> (irq_pending
      && fault_addr == {$past(req_vaddr[31:12]), 12'h000}));

  p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |=> $stable(fault_addr));

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !rsp_fault) |=> !irq_pending);

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !rsp_fault) |=> $stable(irq_pending));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_hit && !rsp_fault));
endmodule

bind proc_tlb proc_tlb_chk #(.CFG_AW(CFG_AW), .PID_W(PID_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .req_valid   (req_valid),
  .req_vaddr   (req_vaddr),
  .req_pid     (req_pid),
  .req_user    (req_user),
  .rsp_paddr   (rsp_paddr),
  .rsp_hit     (rsp_hit),
  .rsp_fault   (rsp_fault),
  .fault_addr  (fault_addr),
  .irq_pending (irq_pending)
);

// File: tb/proc_tlb_tb_top.sv
module proc_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_pid = '0;
  logic        req_user = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_hit;
  logic        rsp_fault;
  logic [31:0] fault_addr;
  logic        irq_pending;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] paddr;
    logic        hit;
    logic        fault;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  proc_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_pid(req_pid), .req_user(req_user), .req_write(req_write),
    .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .fault_addr(fault_addr), .irq_pending(irq_pending)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares lookup responses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (sb.size() == 0) begin
        check("R6 scoreboard empty", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " paddr"}, rsp_paddr, e.paddr);
        check({e.tag, " hit"}, {31'd0, rsp_hit}, {31'd0, e.hit});
        check({e.tag, " fault"}, {31'd0, rsp_fault}, {31'd0, e.fault});
      end
    end
  end

  task automatic drive(logic we, logic [4:0] ca, logic [31:0] cd,
                       logic v, logic [31:0] va, logic [7:0] pid,
                       logic u, logic w);
    @(posedge clk);
    #2;
    cfg_we = we; cfg_addr = ca; cfg_wdata = cd;
    req_valid = v; req_vaddr = va; req_pid = pid;
    req_user = u; req_write = w;
  endtask

  task automatic idle();
    drive(1'b0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic wr(int idx, bit frame, logic [31:0] d);
    drive(1'b1, {idx[1:0], frame, 2'b00}, d, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic look(logic [31:0] va, logic [7:0] pid, logic u, logic w,
                      logic [31:0] pa, logic h, logic f, string tag);
    exp_t e;
    e.paddr = pa; e.hit = h; e.fault = f; e.tag = tag;
    sb.push_back(e);
    drive(1'b0, '0, '0, 1'b1, va, pid, u, w);
  endtask

  task automatic regs(string tag, logic [31:0] fa, logic irq);
    #2;
    check({tag, " fault_addr"}, fault_addr, fa);
    check({tag, " irq"}, {31'd0, irq_pending}, {31'd0, irq});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    regs("R9 reset", 32'h0, 1'b0);
    look(32'h0000_0123, 8'd3, 1, 0, 32'h0000_0123, 0, 1, "R9 empty miss");
    look(32'h0040_0123, 8'd3, 1, 0, 32'h0040_0123, 0, 1, "R6 miss");
    idle();
    regs("R6 latch", 32'h0040_0000, 1'b1);
    // R10: invalid request leaves state alone
    drive(1'b0, '0, '0, 1'b0, 32'h0099_9000, 8'd3, 1'b1, 1'b0);
    #2;
    check("R10 idle fault", {31'd0, rsp_fault}, 32'd0);
    idle();
    regs("R10 hold", 32'h0040_0000, 1'b1);
    // R1/R7: program entry 0, write clears irq
    wr(0, 0, 32'h0040_0007);
    wr(0, 1, 32'h8000_0000);
    idle();
    regs("R7 clear", 32'h0040_0000, 1'b0);
    look(32'h0040_0123, 8'd3, 1, 0, 32'h8000_0123, 1, 0, "R1 R2 R3 read hit");
    look(32'h0040_0FFF, 8'd3, 1, 1, 32'h8000_0FFF, 1, 0, "R4 store allowed");
    look(32'h0040_0123, 8'd4, 1, 0, 32'h0040_0123, 0, 1, "R3 pid mismatch");
    // R4: read-only entry 1
    wr(1, 0, 32'h0050_0006);
    wr(1, 1, 32'h1234_5000);
    look(32'h0050_0ABC, 8'd3, 1, 0, 32'h1234_5ABC, 1, 0, "R4 read ok");
    look(32'h0050_0ABC, 8'd3, 1, 1, 32'h0050_0ABC, 0, 1, "R4 store denied");
    idle();
    regs("R4 fault page", 32'h0050_0000, 1'b1);
    // R5 bypass
    look(32'h0077_7777, 8'd0, 1, 0, 32'h0077_7777, 0, 0, "R5 pid zero");
    look(32'h0040_0123, 8'd3, 0, 1, 32'h0040_0123, 0, 0, "R5 kernel");
    idle();
    regs("R5 no fault", 32'h0050_0000, 1'b1);
    // R8 priority, R2 OR of low frame bits
    wr(2, 0, 32'h0060_000B);
    wr(2, 1, 32'h2222_2000);
    wr(3, 0, 32'h0060_000B);
    wr(3, 1, 32'h3333_3F00);
    look(32'h0060_0010, 8'd5, 1, 0, 32'h2222_2010, 1, 0, "R8 lowest wins");
    wr(2, 0, 32'h0070_000A);
    look(32'h0060_0010, 8'd5, 1, 0, 32'h3333_3F10, 1, 0, "R2 R8 or frame");
    look(32'h0070_0004, 8'd5, 1, 0, 32'h2222_2004, 1, 0, "R1 rewrite");
    // R7: fault in same cycle as window write wins
    drive(1'b1, 5'b00000, 32'h0040_0007, 1'b1, 32'h00AB_C000, 8'd9, 1'b1, 1'b0);
    sb.push_back('{32'h00AB_C000, 1'b0, 1'b1, "R7 fault with write"});
    idle();
    regs("R7 fault wins", 32'h00AB_C000, 1'b1);
    idle();
    check("R6 scoreboard drained", sb.size(), 0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule